// File: doc/BRIEF.md
# In-band XON/XOFF transmit gate

This block sits between a UART receiver and the receive FIFO. Every character the receiver delivers is checked against four programmed codes: a stop code and a go code for the first slot, and a stop code and a go code for the second slot. A stop match pauses the local transmitter and a go match lets it run again. This lets the far end throttle local transmission without a separate handshake wire. Matched control characters are removed from the data stream and raise no interrupt. All other characters go on to the FIFO unchanged. Reception continues while the transmitter is paused.

A 2-bit mode field picks the behaviour. Off passes everything through. The two single-code modes each use one slot. The pair mode acts only when a first-slot code is followed directly by the second-slot code of the same kind. The transmitter's character scheduler reads a pause flag and a start permission. A character already being shifted out finishes, and only the start of the next one is held back. Software must change the mode only with the transmitter disabled, and the block enforces this.

Top module: `xonxoff_gate`

## Requirements
- R1: After reset `fifo_valid_o` is 0, `tx_pause_o` is 0 and the applied mode is off.
- R2: With the applied mode off (`2'b00`), each received character appears on `fifo_char_o` with `fifo_valid_o` high one cycle after its `rx_valid_i`, even when it equals a programmed code, and `tx_pause_o` stays 0.
- R3: In mode `2'b01` a character equal to `xoff1_i` sets `tx_pause_o` one cycle later and a character equal to `xon1_i` clears it. In mode `2'b10` the codes `xoff2_i`/`xon2_i` play that role. A matched character is never forwarded. When the stop and go codes are equal, the stop action wins.
- R4: In the single-code modes a non-matching character is forwarded one cycle after arrival, whether or not the transmitter is paused.
- R5: `tx_go_o` is high exactly when `tx_en_i` is high and `tx_pause_o` is low.
- R6: In mode `2'b11`, `xoff1_i` followed directly by `xoff2_i` pauses the transmitter, and `xon1_i` followed directly by `xon2_i` resumes it. Both characters of the pair are dropped.
- R7: In mode `2'b11` a first-slot code is held back. If the next character does not complete its pair, the held code is forwarded one cycle after that next character arrives. The next character is then forwarded one cycle later, unless it is itself a first-slot code, in which case it is held in turn.
- R8: A new `mode_i` value is applied only in a cycle with `tx_en_i` low, no received character and no pending forwarded character. While `tx_en_i` is high, changes on `mode_i` have no effect.
- R9: Whenever the applied mode is off, `tx_pause_o` is 0 from the next cycle. A held first-slot code is forwarded as data in the cycle after a mode change is applied.
- R10: `rx_valid_i` is never high in two consecutive cycles, which is the UART character rate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | DATA_W | Received character |
| xon1_i | input | DATA_W | First-slot go code |
| xon2_i | input | DATA_W | Second-slot go code |
| xoff1_i | input | DATA_W | First-slot stop code |
| xoff2_i | input | DATA_W | Second-slot stop code |
| mode_i | input | 2 | 00 off, 01 slot-one single, 10 slot-two single, 11 pair |
| tx_en_i | input | 1 | Transmitter enable from software |
| fifo_valid_o | output | 1 | Write strobe toward the receive FIFO |
| fifo_char_o | output | DATA_W | Character toward the receive FIFO |
| tx_pause_o | output | 1 | Transmitter paused by far end |
| tx_go_o | output | 1 | Permission to start the next transmit character |

## Verification
The bench targets the pair mode's broken sequences, such as a stop lead followed by a go tail or a lead followed by another lead. A design that mishandled these would lose the held character, reorder it behind the next one, or pause on half a pair. It also checks equal stop and go codes, where a wrong priority would resume instead of pausing. It tries a mode change while the transmitter is enabled; a leaky mode latch would start forwarding control characters. Finally it turns the feature off while a lead is held and while paused; a wrong design would swallow the held character or leave the transmitter stuck.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    XF_OFF   = 2'b00,
    XF_ONE_A = 2'b01,
    XF_ONE_B = 2'b10,
    XF_PAIR  = 2'b11
  } xf_mode_e;
endpackage

// File: rtl/xf_code_cmp.sv
module xf_code_cmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] char_i,
  input  logic [DATA_W-1:0] stop_code_i,
  input  logic [DATA_W-1:0] go_code_i,
  output logic              stop_hit_o,
  output logic              go_hit_o
);
  // stop has priority when both codes are equal
  assign stop_hit_o = (char_i == stop_code_i);
  assign go_hit_o   = (char_i == go_code_i) && !stop_hit_o;
endmodule

// File: rtl/xf_mode_ctl.sv
module xf_mode_ctl
  import xf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                tx_en_i,
  input  logic                busy_i,
  output xf_mode_e            mode_o,
  output logic                flush_o
);
  xf_mode_e mode_q;
  logic     accept;

  assign accept  = !tx_en_i && !busy_i;
  assign flush_o = accept && (xf_mode_e'(mode_i) != mode_q);
  assign mode_o  = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= XF_OFF;
    else if (accept) mode_q <= xf_mode_e'(mode_i);
  end

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni) tx_en_i |=> $stable(mode_q)); // R8
endmodule

// File: rtl/xf_pause.sv
module xf_pause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_off_i,
  input  logic set_i,
  input  logic clr_i,
  output logic pause_o
);
  logic pause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pause_q <= 1'b0;
    else if (mode_off_i) pause_q <= 1'b0;
    else if (set_i)      pause_q <= 1'b1;
    else if (clr_i)      pause_q <= 1'b0;
  end

  assign pause_o = pause_q;

  AST_OFF_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni) mode_off_i |=> !pause_q); // R9
  AST_SET_PAUSES:  assert property (@(posedge clk_i) disable iff (!rst_ni) set_i |=> pause_q); // R3
  AST_EVENT_EXCL:  assert property (@(posedge clk_i) disable iff (!rst_ni) set_i |-> !clr_i); // R3
endmodule

// File: rtl/xf_filter.sv
module xf_filter
  import xf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  xf_mode_e          mode_i,
  input  logic              flush_i,
  input  logic              lead_stop_i,
  input  logic              lead_go_i,
  input  logic              tail_stop_i,
  input  logic              tail_go_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_char_o,
  output logic              pause_set_o,
  output logic              pause_clr_o,
  output logic              busy_o
);
  logic              out_v_q, n_out_v;
  logic [DATA_W-1:0] out_c_q, n_out_c;
  logic              held_v_q, n_held_v;
  logic              held_stop_q, n_held_stop;
  logic [DATA_W-1:0] held_c_q, n_held_c;
  logic              skid_v_q, n_skid_v;
  logic [DATA_W-1:0] skid_c_q, n_skid_c;

  always_comb begin
    n_out_v     = 1'b0;
    n_out_c     = out_c_q;
    n_held_v    = held_v_q;
    n_held_stop = held_stop_q;
    n_held_c    = held_c_q;
    n_skid_v    = 1'b0;
    n_skid_c    = skid_c_q;
    pause_set_o = 1'b0;
    pause_clr_o = 1'b0;

    if (skid_v_q) begin
      n_out_v = 1'b1;
      n_out_c = skid_c_q;
    end

    // mode change releases a held lead code as data
    if (flush_i && held_v_q) begin
      n_out_v  = 1'b1;
      n_out_c  = held_c_q;
      n_held_v = 1'b0;
    end

    if (rx_valid_i) begin
      unique case (mode_i)
        XF_OFF: begin
          n_out_v = 1'b1;
          n_out_c = rx_char_i;
        end
        XF_ONE_A, XF_ONE_B: begin
          if (lead_stop_i)    pause_set_o = 1'b1;
          else if (lead_go_i) pause_clr_o = 1'b1;
          else begin
            n_out_v = 1'b1;
            n_out_c = rx_char_i;
          end
        end
        XF_PAIR: begin
          if (held_v_q && held_stop_q && tail_stop_i) begin
            pause_set_o = 1'b1;
            n_held_v    = 1'b0;
          end else if (held_v_q && !held_stop_q && tail_go_i) begin
            pause_clr_o = 1'b1;
            n_held_v    = 1'b0;
          end else begin
            if (held_v_q) begin
              n_out_v = 1'b1;
              n_out_c = held_c_q;
            end
            if (lead_stop_i || lead_go_i) begin
              n_held_v    = 1'b1;
              n_held_stop = lead_stop_i;
              n_held_c    = rx_char_i;
            end else begin
              n_held_v = 1'b0;
              if (held_v_q) begin
                // output slot taken by the released lead: defer one cycle
                n_skid_v = 1'b1;
                n_skid_c = rx_char_i;
              end else begin
                n_out_v = 1'b1;
                n_out_c = rx_char_i;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_v_q     <= 1'b0;
      out_c_q     <= '0;
      held_v_q    <= 1'b0;
      held_stop_q <= 1'b0;
      held_c_q    <= '0;
      skid_v_q    <= 1'b0;
      skid_c_q    <= '0;
    end else begin
      out_v_q     <= n_out_v;
      out_c_q     <= n_out_c;
      held_v_q    <= n_held_v;
      held_stop_q <= n_held_stop;
      held_c_q    <= n_held_c;
      skid_v_q    <= n_skid_v;
      skid_c_q    <= n_skid_c;
    end
  end

  assign out_valid_o = out_v_q;
  assign out_char_o  = out_c_q;
  assign busy_o      = skid_v_q;

  AST_RX_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni) rx_valid_i |=> !rx_valid_i); // R10
  AST_OFF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mode_i == XF_OFF) |=> (out_v_q && out_c_q == $past(rx_char_i))); // R2
  AST_SINGLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && (mode_i == XF_ONE_A || mode_i == XF_ONE_B) && (lead_stop_i || lead_go_i)) |=> !out_v_q); // R3
  AST_HELD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mode_i == XF_PAIR && held_v_q && !tail_stop_i && !tail_go_i)
      |=> (out_v_q && out_c_q == $past(held_c_q))); // R7
endmodule

// File: rtl/xonxoff_gate.sv
module xonxoff_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  logic [DATA_W-1:0] xon1_i,
  input  logic [DATA_W-1:0] xon2_i,
  input  logic [DATA_W-1:0] xoff1_i,
  input  logic [DATA_W-1:0] xoff2_i,
  input  logic [1:0]        mode_i,
  input  logic              tx_en_i,
  output logic              fifo_valid_o,
  output logic [DATA_W-1:0] fifo_char_o,
  output logic              tx_pause_o,
  output logic              tx_go_o
);
  import xf_pkg::*;

  xf_mode_e          mode_q;
  logic              flush, skid_busy, busy;
  logic [DATA_W-1:0] lead_stop_code, lead_go_code;
  logic              lead_stop, lead_go, tail_stop, tail_go;
  logic              pz_set, pz_clr, pause;

  assign busy = rx_valid_i || skid_busy;

  xf_mode_ctl u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .tx_en_i (tx_en_i),
    .busy_i  (busy),
    .mode_o  (mode_q),
    .flush_o (flush)
  );

  // slot-two single mode uses the second code pair as its only pair
  assign lead_stop_code = (mode_q == XF_ONE_B) ? xoff2_i : xoff1_i;
  assign lead_go_code   = (mode_q == XF_ONE_B) ? xon2_i  : xon1_i;

  xf_code_cmp #(.DATA_W(DATA_W)) u_lead_cmp (
    .char_i      (rx_char_i),
    .stop_code_i (lead_stop_code),
    .go_code_i   (lead_go_code),
    .stop_hit_o  (lead_stop),
    .go_hit_o    (lead_go)
  );

  xf_code_cmp #(.DATA_W(DATA_W)) u_tail_cmp (
    .char_i      (rx_char_i),
    .stop_code_i (xoff2_i),
    .go_code_i   (xon2_i),
    .stop_hit_o  (tail_stop),
    .go_hit_o    (tail_go)
  );

  xf_filter #(.DATA_W(DATA_W)) u_filter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_valid_i  (rx_valid_i),
    .rx_char_i   (rx_char_i),
    .mode_i      (mode_q),
    .flush_i     (flush),
    .lead_stop_i (lead_stop),
    .lead_go_i   (lead_go),
    .tail_stop_i (tail_stop),
    .tail_go_i   (tail_go),
    .out_valid_o (fifo_valid_o),
    .out_char_o  (fifo_char_o),
    .pause_set_o (pz_set),
    .pause_clr_o (pz_clr),
    .busy_o      (skid_busy)
  );

  xf_pause u_pause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_off_i (mode_q == XF_OFF),
    .set_i      (pz_set),
    .clr_i      (pz_clr),
    .pause_o    (pause)
  );

  assign tx_pause_o = pause;
  assign tx_go_o    = tx_en_i && !pause;

  AST_PAUSED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_pause_o) |-> !tx_go_o); // R5
endmodule

// File: tb/xonxoff_gate_bench.sv
module xonxoff_gate_bench;
  localparam logic [7:0] XON1 = 8'h11, XOFF1 = 8'h13, XON2 = 8'h91, XOFF2 = 8'h93;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_v = 1'b0;
  logic [7:0] rx_c = '0;
  logic [7:0] xon1 = XON1, xon2 = XON2, xoff1 = XOFF1, xoff2 = XOFF2;
  logic [1:0] mode = 2'b00;
  logic       tx_en = 1'b1;
  logic       fv;
  logic [7:0] fc;
  logic       pz, go;

  always #2 clk = ~clk;

  xonxoff_gate #(.DATA_W(8)) u_xonxoff_gate (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_v), .rx_char_i(rx_c),
    .xon1_i(xon1), .xon2_i(xon2), .xoff1_i(xoff1), .xoff2_i(xoff2),
    .mode_i(mode), .tx_en_i(tx_en),
    .fifo_valid_o(fv), .fifo_char_o(fc), .tx_pause_o(pz), .tx_go_o(go)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] got_q[$], exp_q[$];
  int   m_mode = 0;
  bit   m_pause = 0, m_held = 0, m_hstop = 0;
  logic [7:0] m_hc = '0;
  logic n1_v, n2_v;
  logic [7:0] n1_c, n2_c;

  always @(negedge clk) if (rst_n && fv) got_q.push_back(fc);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic void model_rx(input logic [7:0] c);
    logic [7:0] s, g;
    case (m_mode)
      0: exp_q.push_back(c);
      1, 2: begin
        s = (m_mode == 2) ? xoff2 : xoff1;
        g = (m_mode == 2) ? xon2 : xon1;
        if (c == s) m_pause = 1;
        else if (c == g) m_pause = 0;
        else exp_q.push_back(c);
      end
      default: begin
        if (m_held && m_hstop && c == xoff2) begin m_pause = 1; m_held = 0; end
        else if (m_held && !m_hstop && c == xon2 && c != xoff2) begin m_pause = 0; m_held = 0; end
        else begin
          if (m_held) exp_q.push_back(m_hc);
          if (c == xoff1) begin m_held = 1; m_hstop = 1; m_hc = c; end
          else if (c == xon1) begin m_held = 1; m_hstop = 0; m_hc = c; end
          else begin m_held = 0; exp_q.push_back(c); end
        end
      end
    endcase
  endfunction

  function automatic void model_mode(input int m);
    if (m != m_mode && m_held) begin exp_q.push_back(m_hc); m_held = 0; end
    m_mode = m;
    if (m == 0) m_pause = 0;
  endfunction

  task automatic send(input logic [7:0] c);
    @(negedge clk); rx_v = 1'b1; rx_c = c; model_rx(c);
    @(negedge clk); rx_v = 1'b0; n1_v = fv; n1_c = fc;
    @(negedge clk); n2_v = fv; n2_c = fc;
  endtask

  task automatic set_mode(input int m);
    @(negedge clk); tx_en = 1'b0; mode = 2'(m);
    @(negedge clk); @(negedge clk);
    model_mode(m);
  endtask

  task automatic compare(input string req);
    @(negedge clk); @(negedge clk);
    chk(got_q.size() == exp_q.size(), req, "stream length", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(got_q[i] == exp_q[i], req, "stream char", got_q[i], exp_q[i]);
    chk(pz == m_pause, req, "pause", pz, m_pause);
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    chk(fv == 0, "R1", "fifo_valid in reset", fv, 0);
    chk(pz == 0, "R1", "pause in reset", pz, 0);
    chk(go == 1, "R5", "go in reset with tx_en", go, 1);
    @(negedge clk); rst_n = 1'b1;

    // R1/R2: off mode forwards codes
    send(XOFF1);
    chk(n1_v && n1_c == XOFF1, "R2", "off passthrough", n1_c, XOFF1);
    chk(pz == 0, "R2", "off no pause", pz, 0);
    compare("R2");

    // R3/R4/R5 single slot one
    set_mode(1);
    send(8'h41);
    chk(n1_v && n1_c == 8'h41, "R4", "data latency", n1_c, 8'h41);
    send(XOFF1);
    chk(!n1_v, "R3", "xoff dropped", n1_v, 0);
    chk(pz == 1, "R3", "xoff pauses", pz, 1);
    tx_en = 1'b1; #1;
    chk(go == 0, "R5", "go blocked when paused", go, 0);
    send(8'h42);
    chk(n1_v && n1_c == 8'h42, "R4", "rx while paused", n1_c, 8'h42);
    send(XON1);
    chk(pz == 0, "R3", "xon resumes", pz, 0);
    chk(go == 1, "R5", "go restored", go, 1);
    send(XOFF2);
    chk(n1_v && n1_c == XOFF2, "R3", "slot two code is data in mode 01", n1_c, XOFF2);
    compare("R3");

    // slot two single
    set_mode(2);
    send(XOFF2);
    chk(pz == 1, "R3", "mode 10 xoff2 pauses", pz, 1);
    send(XON1);
    chk(n1_v && n1_c == XON1, "R3", "mode 10 slot one is data", n1_c, XON1);
    send(XON2);
    chk(pz == 0, "R3", "mode 10 xon2 resumes", pz, 0);
    compare("R3");

    // equal stop and go codes: stop wins
    set_mode(1);
    xon1 = XOFF1;
    send(XOFF1);
    chk(pz == 1, "R3", "equal codes stop wins", pz, 1);
    xon1 = XON1;
    send(XON1);
    compare("R3");

    // R8: mode change ignored while transmitter enabled
    send(XOFF1);
    tx_en = 1'b1; mode = 2'b00;
    repeat (3) @(negedge clk);
    send(XON1);
    chk(!n1_v, "R8", "mode held while tx enabled", n1_v, 0);
    chk(pz == 0, "R8", "still filtering", pz, 0);
    compare("R8");
    set_mode(0);
    send(XON1);
    chk(n1_v && n1_c == XON1, "R8", "mode applied after tx off", n1_c, XON1);
    compare("R8");

    // R6/R7 pair mode
    set_mode(3);
    send(XOFF1);
    chk(!n1_v && !n2_v, "R7", "lead held", n1_v, 0);
    chk(pz == 0, "R6", "half pair no pause", pz, 0);
    send(XOFF2);
    chk(pz == 1, "R6", "pair pauses", pz, 1);
    chk(!n1_v && !n2_v, "R6", "pair dropped", n1_v, 0);
    send(XON1); send(XON2);
    chk(pz == 0, "R6", "pair resumes", pz, 0);
    send(XOFF1); send(8'h43);
    chk(n1_v && n1_c == XOFF1, "R7", "held released first", n1_c, XOFF1);
    chk(n2_v && n2_c == 8'h43, "R7", "breaker follows", n2_c, 8'h43);
    send(XON1); send(XOFF1);
    chk(n1_v && n1_c == XON1, "R7", "lead replaces lead", n1_c, XON1);
    chk(!n2_v, "R7", "new lead held", n2_v, 0);
    send(XON2);
    chk(n1_v && n1_c == XOFF1, "R7", "go tail breaks stop lead", n1_c, XOFF1);
    chk(n2_v && n2_c == XON2, "R7", "tail forwarded", n2_c, XON2);
    send(XOFF1); send(XOFF2);
    chk(pz == 1, "R6", "paused before off", pz, 1);
    send(XON1);
    compare("R6 R7");
    set_mode(0);
    chk(pz == 0, "R9", "off clears pause", pz, 0);
    compare("R9");

    // random
    for (int i = 0; i < 400; i++) begin
      logic [7:0] pool [8];
      logic [7:0] c;
      pool = '{XON1, XOFF1, XON2, XOFF2, 8'h20, 8'h41, 8'h7e, 8'h00};
      if ($urandom % 12 == 0) set_mode(int'($urandom % 4));
      if ($urandom % 4 == 0) tx_en = ($urandom % 2) == 1;
      c = ($urandom % 10 == 0) ? 8'($urandom) : pool[$urandom % 8];
      send(c);
      if (i % 16 == 15) begin
        compare("R3 R4 R6 R7 R9 random");
        chk(go == (tx_en && !m_pause), "R5", "go random", go, tx_en && !m_pause);
      end
    end
    compare("R3 R4 R6 R7 R9 random");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule